// File: doc/BRIEF.md
# DMA Completion Response Port

When the transfer engine finishes a descriptor, it hands over one completion record on a valid/ready stream. This block keeps those records in a FIFO until the host reads them. Each record has three parts: a 32-bit count of bytes moved, an 8-bit error code and a flag that marks early termination. The host sees the oldest record through a read window that is two words wide. A read of the second word, the status word, retires the record, so a driver must read the byte count first and the status word second to consume each completion.

The block also exports the number of queued records as a 16-bit fill level, along with empty and full flags, for a status register that lives elsewhere. When the queue is full, the transfer engine is held back through its ready signal.

Top module: `dma_resp_port`

## Requirements
- R1: A read at byte offset 0x0 returns the byte count of the oldest queued record on `rd_data_o`.
- R2: A read at byte offset 0x4 returns the status word of the oldest record, with the error code in bits 7:0, the early-termination flag in bit 8 and zeros in bits 31:9.
- R3: A strobed read at offset 0x4 while the queue is not empty removes the oldest record, so the fill level drops by one at the next clock edge.
- R4: A read at offset 0x0 never removes a record; the fill level is unchanged after it.
- R5: While the queue is empty, a read at any offset returns zero and changes nothing.
- R6: `rsp_ready_o` is low whenever the queue holds DEPTH records, and a record offered in that state is not stored.
- R7: `fill_level_o` equals the number of queued records, zero-extended to 16 bits, and never exceeds DEPTH.
- R8: When a record is accepted in the same cycle as a status-word read that retires one, the fill level stays the same.
- R9: `empty_o` is high exactly when the fill level is zero, and `full_o` is high exactly when it equals DEPTH.
- R10: Records are read out in the order they were accepted.
- R11: A read at any offset other than 0x0 or 0x4 returns zero and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rsp_valid_i | input | 1 | The transfer engine offers a completion record |
| rsp_ready_o | output | 1 | The queue can accept a record |
| rsp_bytes_i | input | 32 | Bytes transferred for the finished descriptor |
| rsp_err_i | input | 8 | Error code for the finished descriptor |
| rsp_early_i | input | 1 | The descriptor ended before its full length |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | ADDR_W | Byte offset inside the read window |
| rd_data_o | output | 32 | Word at the addressed offset of the oldest record |
| fill_level_o | output | 16 | Number of queued records |
| empty_o | output | 1 | No record is queued |
| full_o | output | 1 | The queue holds DEPTH records |

## Verification
The assertions assume that `rd_en_i` and `rd_addr_i` change only between clock edges and that the transfer engine may offer a record in any cycle, including while the queue is full. Under that assumption, a status-word read on a non-empty queue with no push in the same cycle always lowers the fill level by one. The bench drives every input at the falling edge and samples half a period later. It fills the queue to DEPTH, then keeps a record valid against a low ready. It drains the queue through every offset, including an undecoded one. It also places one push and one pop in the same cycle, so that no stimulus lies outside what the properties expect.

// File: rtl/resp_pkg.sv
package resp_pkg;
  localparam int unsigned BYTES_W = 32;
  localparam int unsigned ERR_W   = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LVL_W   = 16;
  // byte offsets inside the host read window
  localparam int unsigned OFS_BYTES = 0;
  localparam int unsigned OFS_STAT  = 4;

  typedef struct packed {
    logic               early;
    logic [ERR_W-1:0]   err;
    logic [BYTES_W-1:0] bytes;
  } resp_t;
endpackage

// File: rtl/resp_fifo.sv
module resp_fifo
  import resp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  resp_t         data_i,
  input  logic          pop_i,
  output resp_t         head_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  resp_t         mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_next(rd_ptr_q);
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
endmodule

// File: rtl/resp_read_mux.sv
module resp_read_mux
  import resp_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  resp_t             head_i,
  input  logic              empty_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pop_o
);
  logic sel_bytes, sel_stat;

  assign sel_bytes = (rd_addr_i == ADDR_W'(OFS_BYTES));
  assign sel_stat  = (rd_addr_i == ADDR_W'(OFS_STAT));

  // the status-word read is the only way to retire a record
  assign pop_o = rd_en_i && sel_stat && !empty_i;

  always_comb begin
    rd_data_o = '0;
    if (!empty_i) begin
      if (sel_bytes)
        rd_data_o = DATA_W'(head_i.bytes);
      else if (sel_stat)
        rd_data_o = DATA_W'({head_i.early, head_i.err});
    end
  end
endmodule

// File: rtl/dma_resp_port.sv
module dma_resp_port
  import resp_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [31:0]       rsp_bytes_i,
  input  logic [7:0]        rsp_err_i,
  input  logic              rsp_early_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic [15:0]       fill_level_o,
  output logic              empty_o,
  output logic              full_o
);
  resp_t         in_rec, head;
  logic          push, pop, empty, full;
  logic [CW-1:0] count;

  assign in_rec = '{early: rsp_early_i, err: rsp_err_i, bytes: rsp_bytes_i};
  assign push   = rsp_valid_i && !full;

  resp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (in_rec),
    .pop_i   (pop),
    .head_o  (head),
    .count_o (count),
    .empty_o (empty),
    .full_o  (full)
  );

  resp_read_mux #(.ADDR_W(ADDR_W)) u_mux (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .head_i    (head),
    .empty_i   (empty),
    .rd_data_o (rd_data_o),
    .pop_o     (pop)
  );

  assign rsp_ready_o  = !full;
  assign fill_level_o = LVL_W'(count);
  assign empty_o      = empty;
  assign full_o       = full;
endmodule

// File: rtl/resp_port_checker.sv
module resp_port_checker #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rsp_valid_i,
  input logic              rsp_ready_o,
  input logic [31:0]       rsp_bytes_i,
  input logic [7:0]        rsp_err_i,
  input logic              rsp_early_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [31:0]       rd_data_o,
  input logic [15:0]       fill_level_o,
  input logic              empty_o,
  input logic              full_o
);
  logic acc, stat_rd, bytes_rd;
  assign acc      = rsp_valid_i && rsp_ready_o;
  assign stat_rd  = rd_en_i && (rd_addr_i == ADDR_W'(4)) && !empty_o;
  assign bytes_rd = rd_en_i && (rd_addr_i == ADDR_W'(0));

  a_r6_no_accept_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !rsp_ready_o);

  a_r6_full_holds_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !stat_rd) |=> (fill_level_o == 16'(DEPTH)));

  a_r3_status_read_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !acc) |=> (fill_level_o == $past(fill_level_o) - 16'd1));

  a_r4_bytes_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bytes_rd && !acc) |=> $stable(fill_level_o));

  a_r8_push_pop_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && stat_rd) |=> $stable(fill_level_o));

  a_r5_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == 32'd0));

  a_r7_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_level_o <= 16'(DEPTH));

  a_r9_flags_match_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o == (fill_level_o == 16'd0)) && (full_o == (fill_level_o == 16'(DEPTH))));
endmodule

bind dma_resp_port resp_port_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dma_resp_port.sv
module tb_dma_resp_port;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rsp_valid_i = 1'b0;
  logic              rsp_ready_o;
  logic [31:0]       rsp_bytes_i = '0;
  logic [7:0]        rsp_err_i = '0;
  logic              rsp_early_i = 1'b0;
  logic              rd_en_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [31:0]       rd_data_o;
  logic [15:0]       fill_level_o;
  logic              empty_o, full_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dma_resp_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o),
    .rsp_bytes_i(rsp_bytes_i), .rsp_err_i(rsp_err_i), .rsp_early_i(rsp_early_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .fill_level_o(fill_level_o), .empty_o(empty_o), .full_o(full_o)
  );

  function automatic logic [31:0] exp_bytes(int i);
    return 32'(i * 260 + 3);
  endfunction
  function automatic logic [7:0] exp_err(int i);
    return 8'(i * 37 + 1);
  endfunction
  function automatic logic exp_early(int i);
    return (i % 2) == 1;
  endfunction
  function automatic logic [31:0] exp_stat(int i);
    return {23'd0, exp_early(i), exp_err(i)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive_rec(int i);
    rsp_bytes_i = exp_bytes(i);
    rsp_err_i   = exp_err(i);
    rsp_early_i = exp_early(i);
  endtask

  task automatic push_one(int i);
    @(negedge clk);
    rsp_valid_i = 1'b1;
    drive_rec(i);
    @(posedge clk);
    #1 rsp_valid_i = 1'b0;
  endtask

  // returns the combinational word seen before the edge
  task automatic read_word(int ofs, output logic [31:0] data);
    @(negedge clk);
    rd_en_i   = 1'b1;
    rd_addr_i = ADDR_W'(ofs);
    #1 data = rd_data_o;
    @(posedge clk);
    #1 rd_en_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] lvl;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // reset state
    #1;
    chk("R7 reset level", 32'(fill_level_o), 0);
    chk("R9 reset empty", 32'(empty_o), 1);
    chk("R9 reset full", 32'(full_o), 0);
    chk("R6 reset ready", 32'(rsp_ready_o), 1);

    // empty reads at every offset
    for (int o = 0; o < (1 << ADDR_W); o++) begin
      read_word(o, d);
      chk("R5 empty read data", d, 0);
      chk("R5 empty read level", 32'(fill_level_o), 0);
    end

    // fill to DEPTH
    for (int i = 0; i < DEPTH; i++) begin
      push_one(i);
      chk("R7 level after push", 32'(fill_level_o), 32'(i + 1));
      chk("R9 empty after push", 32'(empty_o), 0);
      chk("R9 full after push", 32'(full_o), (i + 1 == DEPTH) ? 1 : 0);
    end
    chk("R6 ready low when full", 32'(rsp_ready_o), 0);

    // offered record while full must be dropped
    @(negedge clk);
    rsp_valid_i = 1'b1;
    drive_rec(99);
    repeat (2) @(posedge clk);
    #1 rsp_valid_i = 1'b0;
    chk("R6 level held while full", 32'(fill_level_o), DEPTH);

    // drain in order through every offset
    for (int i = 0; i < DEPTH; i++) begin
      lvl = fill_level_o;
      read_word(0, d);
      chk("R1 byte count", d, exp_bytes(i));
      read_word(0, d);
      chk("R4 byte read repeat", d, exp_bytes(i));
      chk("R4 level after byte read", 32'(fill_level_o), 32'(lvl));
      for (int o = 1; o < (1 << ADDR_W); o++) begin
        if (o != 4) begin
          read_word(o, d);
          chk("R11 undecoded data", d, 0);
        end
      end
      chk("R11 level after undecoded", 32'(fill_level_o), 32'(lvl));
      read_word(4, d);
      chk("R2 R10 status word", d, exp_stat(i));
      chk("R3 level after status read", 32'(fill_level_o), 32'(lvl) - 1);
    end
    chk("R9 empty after drain", 32'(empty_o), 1);
    chk("R6 ready after drain", 32'(rsp_ready_o), 1);
    read_word(4, d);
    chk("R5 status read empty", d, 0);
    chk("R5 level stays zero", 32'(fill_level_o), 0);

    // push and pop in the same cycle
    push_one(40);
    @(negedge clk);
    rsp_valid_i = 1'b1;
    drive_rec(41);
    rd_en_i   = 1'b1;
    rd_addr_i = ADDR_W'(4);
    #1 d = rd_data_o;
    @(posedge clk);
    #1 begin
      rsp_valid_i = 1'b0;
      rd_en_i     = 1'b0;
    end
    chk("R8 retired word", d, exp_stat(40));
    chk("R8 level unchanged", 32'(fill_level_o), 1);
    read_word(0, d);
    chk("R10 next byte count", d, exp_bytes(41));
    read_word(4, d);
    chk("R10 next status", d, exp_stat(41));
    chk("R9 empty at end", 32'(empty_o), 1);

    done = 1'b1;
    finish_run();
  end
endmodule